// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the control logic of a 128K x 16 flash array. It watches each host write strobe, carrying an address and a data word already captured by the bus interface. It matches the writes against the multi-cycle unlock and command sequences the array accepts. When a sequence completes, the block raises a one-clock start pulse for the selected operation:

- word program
- sector erase
- chip erase
- boot-region lock enable
- identification mode entry
- identification mode exit

It also hands over the operands. For a word program these are the target address and data; for a sector erase, the sector address.

Every sequence opens with two unlock writes. The third write picks a short command, or it opens a longer six-write sequence whose last write chooses among the erase and lock operations. While the array reports an embedded operation in progress, host writes are discarded. The sequence state is kept intact until the operation finishes. A write that does not fit the expected step drops the decoder back to idle.

Top module: `flash_cmd_seq`

## Requirements
- R1: The first two writes of every sequence are data 0xAA at command address 0x5555, then data 0x55 at command address 0x2AAA. Any other opening produces no pulse.
- R2: A third write of 0xA0 to 0x5555, followed by a fourth write to any address, raises `start_prog` for one clock. `op_addr` and `op_data` then hold that fourth write's full address and data.
- R3: A third write of 0x80 to 0x5555, then 0xAA to 0x5555, 0x55 to 0x2AAA and 0x10 to 0x5555, raises `start_chip_erase`.
- R4: The same five-write prefix as R3, closed by 0x40 to 0x5555, raises `start_boot_lock`.
- R5: The same five-write prefix as R3, closed by 0x30 to any address, raises `start_sector_erase`. `op_addr` then holds that write's full address.
- R6: A third write of 0x90 to 0x5555 raises `id_enter` and sets `id_mode` to 1.
- R7: Identification mode exits through either of two routes. The first is the two unlock writes followed by 0xF0 to 0x5555. The second is a single 0xF0 to any address while the decoder is idle. Either route raises `id_exit` and clears `id_mode`.
- R8: Only data bits 7..0 are compared against command codes. Bits 15..8 have no effect on decoding.
- R9: A write presented while `busy` is 1 is ignored. No pulse is raised, and the sequence in progress continues with the next write made while `busy` is 0.
- R10: While `rst_n` is 0, all pulses and `id_mode` are 0. After reset the decoder is idle, so any partial sequence is abandoned.
- R11: A write that does not match the expected step returns the decoder to idle. A later completion of the abandoned sequence raises no pulse.
- R12: Command addresses are compared on address bits 14..0 only. Bit 16 has no effect on command matching.
- R13: Each start pulse is high for exactly the one clock after the edge that samples the final write of its sequence. At most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one clock per write |
| wr_addr | input | 17 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| busy | input | 1 | Embedded program or erase in progress |
| start_prog | output | 1 | Word program launch pulse |
| start_sector_erase | output | 1 | Sector erase launch pulse |
| start_chip_erase | output | 1 | Chip erase launch pulse |
| start_boot_lock | output | 1 | Boot-region lock enable pulse |
| id_enter | output | 1 | Identification mode entry pulse |
| id_exit | output | 1 | Identification mode exit pulse |
| op_addr | output | 17 | Captured program or sector address |
| op_data | output | 16 | Captured program data |
| id_mode | output | 1 | Identification mode active |

## Verification
The hardest situation to reach from the ports is a six-write sequence broken deep inside, or paused by `busy` halfway through. In both cases the correct outcome depends on the decoder's hidden step count, not on the last write alone. The stimulus builds whole command scripts at random and mutates them: it flips a code byte in about one write in ten, and asserts `busy` on about one write in twelve. Random high data bytes and a random address bit 16 ride on every write. A bench model of the sequence rules follows along and predicts every pulse. Directed cases add a reset in the middle of a sequence, a break at the fifth write of an erase, and a busy-held unlock write.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int CMP_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              start_prog,
  output logic              start_sector_erase,
  output logic              start_chip_erase,
  output logic              start_boot_lock,
  output logic              id_enter,
  output logic              id_exit,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              id_mode
);
  localparam logic [CMP_W-1:0] ADR_A = CMP_W'(15'h5555);
  localparam logic [CMP_W-1:0] ADR_B = CMP_W'(15'h2AAA);

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_EXT1, S_EXT2, S_EXT3
  } step_t;

  step_t st;
  logic  take, at_a, at_b;
  logic [7:0] code;

  assign take = wr_en && !busy;
  assign code = wr_data[7:0];
  assign at_a = wr_addr[CMP_W-1:0] == ADR_A;
  assign at_b = wr_addr[CMP_W-1:0] == ADR_B;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st                 <= S_IDLE;
      start_prog         <= 1'b0;
      start_sector_erase <= 1'b0;
      start_chip_erase   <= 1'b0;
      start_boot_lock    <= 1'b0;
      id_enter           <= 1'b0;
      id_exit            <= 1'b0;
      id_mode            <= 1'b0;
      op_addr            <= '0;
      op_data            <= '0;
    end else begin
      start_prog         <= 1'b0;
      start_sector_erase <= 1'b0;
      start_chip_erase   <= 1'b0;
      start_boot_lock    <= 1'b0;
      id_enter           <= 1'b0;
      id_exit            <= 1'b0;
      if (take) begin
        st <= S_IDLE;
        unique case (st)
          S_IDLE: begin
            if (at_a && code == 8'hAA) st <= S_UNL1;
            else if (code == 8'hF0) begin
              id_exit <= 1'b1;
              id_mode <= 1'b0;
            end
          end
          S_UNL1: if (at_b && code == 8'h55) st <= S_UNL2;
          S_UNL2: begin
            if (at_a) begin
              case (code)
                8'hA0: st <= S_PROG;
                8'h80: st <= S_EXT1;
                8'h90: begin
                  id_enter <= 1'b1;
                  id_mode  <= 1'b1;
                end
                8'hF0: begin
                  id_exit <= 1'b1;
                  id_mode <= 1'b0;
                end
                default: ;
              endcase
            end
          end
          S_PROG: begin
            start_prog <= 1'b1;
            op_addr    <= wr_addr;
            op_data    <= wr_data;
          end
          S_EXT1: if (at_a && code == 8'hAA) st <= S_EXT2;
          S_EXT2: if (at_b && code == 8'h55) st <= S_EXT3;
          S_EXT3: begin
            if (code == 8'h30) begin
              start_sector_erase <= 1'b1;
              op_addr            <= wr_addr;
            end else if (at_a && code == 8'h10) start_chip_erase <= 1'b1;
            else if (at_a && code == 8'h40) start_boot_lock <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_one_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_sector_erase, start_chip_erase,
              start_boot_lock, id_enter, id_exit}));
  assert_prog_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |=> !start_prog);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> ($stable(st) && !start_prog && !start_chip_erase &&
                         !start_sector_erase && !start_boot_lock));
  assert_enter_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    id_enter |-> id_mode);
  assert_exit_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_exit |-> !id_mode);
  assert_no_write_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !busy) |=> !(start_prog || start_sector_erase || start_chip_erase ||
                            start_boot_lock || id_enter || id_exit));
  assert_idle_after_reset_R10: assert property (@(posedge clk)
    !rst_n |=> (st == S_IDLE && !id_mode));
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        start_prog, start_sector_erase, start_chip_erase;
  logic        start_boot_lock, id_enter, id_exit, id_mode;
  logic [16:0] op_addr;
  logic [15:0] op_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int          m_st = 0;
  bit          m_id = 0;
  logic [5:0]  m_p;
  logic [16:0] m_addr = '0;
  logic [15:0] m_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .start_prog(start_prog), .start_sector_erase(start_sector_erase),
    .start_chip_erase(start_chip_erase), .start_boot_lock(start_boot_lock),
    .id_enter(id_enter), .id_exit(id_exit), .op_addr(op_addr), .op_data(op_data),
    .id_mode(id_mode));

  function automatic logic [5:0] pulses();
    return {start_prog, start_sector_erase, start_chip_erase,
            start_boot_lock, id_enter, id_exit};
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic model(logic [16:0] a, logic [15:0] d, bit b);
    bit aa, ab;
    logic [7:0] c;
    aa = a[14:0] == 15'h5555;
    ab = a[14:0] == 15'h2AAA;
    c = d[7:0];
    m_p = '0;
    if (b) return;
    case (m_st)
      0: if (aa && c == 8'hAA) m_st = 1;
         else begin m_st = 0; if (c == 8'hF0) begin m_p[0] = 1; m_id = 0; end end
      1: m_st = (ab && c == 8'h55) ? 2 : 0;
      2: begin
           m_st = 0;
           if (aa && c == 8'hA0) m_st = 3;
           else if (aa && c == 8'h80) m_st = 4;
           else if (aa && c == 8'h90) begin m_p[1] = 1; m_id = 1; end
           else if (aa && c == 8'hF0) begin m_p[0] = 1; m_id = 0; end
         end
      3: begin m_st = 0; m_p[5] = 1; m_addr = a; m_data = d; end
      4: m_st = (aa && c == 8'hAA) ? 5 : 0;
      5: m_st = (ab && c == 8'h55) ? 6 : 0;
      default: begin
           m_st = 0;
           if (c == 8'h30) begin m_p[4] = 1; m_addr = a; end
           else if (aa && c == 8'h10) m_p[3] = 1;
           else if (aa && c == 8'h40) m_p[2] = 1;
         end
    endcase
  endtask

  task automatic wr(logic [16:0] a, logic [15:0] d, bit b = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_en = 0; busy = 0;
    model(a, d, b);
  endtask

  task automatic wr_chk(string tag, logic [16:0] a, logic [15:0] d, bit b = 0);
    wr(a, d, b);
    chk({tag, " pulses"}, 64'(pulses()), 64'(m_p));
    chk({tag, " id_mode"}, 64'(id_mode), 64'(m_id));
    if (m_p[5]) begin
      chk({tag, " op_addr"}, 64'(op_addr), 64'(m_addr));
      chk({tag, " op_data"}, 64'(op_data), 64'(m_data));
    end
    if (m_p[4]) chk({tag, " op_addr"}, 64'(op_addr), 64'(m_addr));
  endtask

  task automatic unlock(logic [7:0] hi = 8'h00);
    wr(17'h05555, {hi, 8'hAA});
    wr(17'h02AAA, {hi, 8'h55});
  endtask

  task automatic script(int k);
    logic [16:0] a [6];
    logic [7:0]  c [6];
    int n;
    a[0] = 17'h05555; c[0] = 8'hAA;
    a[1] = 17'h02AAA; c[1] = 8'h55;
    a[2] = 17'h05555; a[3] = 17'h05555; c[3] = 8'hAA;
    a[4] = 17'h02AAA; c[4] = 8'h55; a[5] = 17'h05555;
    n = 6;
    case (k)
      0: begin c[2] = 8'hA0; n = 4; a[3] = 17'($urandom); c[3] = 8'($urandom); end
      1: begin c[2] = 8'h80; c[5] = 8'h10; end
      2: begin c[2] = 8'h80; c[5] = 8'h40; end
      3: begin c[2] = 8'h80; c[5] = 8'h30; a[5] = 17'($urandom); end
      4: begin c[2] = 8'h90; n = 3; end
      5: begin c[2] = 8'hF0; n = 3; end
      default: begin n = 1; c[0] = 8'hF0; a[0] = 17'($urandom); end
    endcase
    for (int i = 0; i < n; i++) begin
      logic [7:0] cc;
      logic [16:0] aa;
      cc = c[i];
      aa = {1'($urandom % 2), a[i][15:0]};
      if ($urandom % 10 == 0) cc = cc ^ 8'(1 << ($urandom % 8));
      wr_chk("random R1 R8 R9 R12", aa, {8'($urandom), cc}, ($urandom % 12) == 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R10 reset pulses", 64'(pulses()), 64'h0);
    chk("R10 reset id_mode", 64'(id_mode), 64'h0);
    rst_n = 1;

    unlock(8'h3C); wr(17'h15555, 16'hC7A0);
    wr_chk("R2 R8 R12 program", 17'h1ABCD, 16'h1234);
    chk("R2 op_addr", 64'(op_addr), 64'h1ABCD);
    chk("R2 op_data", 64'(op_data), 64'h1234);
    @(negedge clk);
    chk("R13 prog pulse ends", 64'(pulses()), 64'h0);

    unlock(); wr(17'h05555, 16'h0080); unlock();
    wr_chk("R3 chip erase", 17'h05555, 16'hFF10);
    chk("R3 chip pulse", 64'(start_chip_erase), 64'h1);

    unlock(); wr(17'h05555, 16'h0080); unlock();
    wr_chk("R4 boot lock", 17'h05555, 16'h0040);
    chk("R4 lock pulse", 64'(start_boot_lock), 64'h1);

    unlock(); wr(17'h05555, 16'h0080); unlock();
    wr_chk("R5 sector erase", 17'h03123, 16'h0030);
    chk("R5 sector addr", 64'(op_addr), 64'h03123);

    unlock(); wr_chk("R6 id enter", 17'h05555, 16'h0090);
    chk("R6 id_mode set", 64'(id_mode), 64'h1);
    unlock(); wr_chk("R7 three-write exit", 17'h05555, 16'h00F0);
    chk("R7 id_mode clear", 64'(id_mode), 64'h0);
    unlock(); wr(17'h05555, 16'h0090);
    wr_chk("R7 single exit", 17'h0F00D, 16'hA5F0);
    chk("R7 single exit pulse", 64'(id_exit), 64'h1);

    wr(17'h05555, 16'h00AA); wr(17'h02AAB, 16'h0055);
    wr_chk("R1 bad unlock address", 17'h05555, 16'h0090);
    chk("R1 no id mode", 64'(id_mode), 64'h0);

    unlock(); wr(17'h05555, 16'h0080); wr(17'h05555, 16'h00AA);
    wr(17'h02AAA, 16'h0077); wr(17'h02AAA, 16'h0055);
    wr_chk("R11 broken erase", 17'h05555, 16'h0010);
    chk("R11 no chip erase", 64'(start_chip_erase), 64'h0);

    wr(17'h05555, 16'h00AA); wr(17'h02AAA, 16'h00A0, 1);
    wr(17'h02AAA, 16'h0055); wr(17'h05555, 16'h00A0);
    wr_chk("R9 busy write ignored", 17'h00042, 16'hBEEF);
    chk("R9 program after busy", 64'(start_prog), 64'h1);

    unlock(); wr(17'h05555, 16'h00A0, 1);
    wr_chk("R9 busy final write", 17'h05555, 16'h00A0);
    wr_chk("R9 program resumes", 17'h00007, 16'h0707);

    unlock();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    m_st = 0; m_id = 0;
    wr_chk("R10 partial abandoned", 17'h05555, 16'h0090);
    chk("R10 no entry", 64'(id_mode), 64'h0);

    for (int i = 0; i < 400; i++) script(int'($urandom % 7));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule